// File: doc/BRIEF.md
# Bus Master Transaction Sequencer for a Multiplexed 32-bit Bus

This block is the initiator side of a shared parallel bus on which address and data are carried on the same 32 wires, with active-low control lines and a separate command/byte-enable group. A local agent posts one request at a time. Each request carries a bus command, a start address, a direction, a word count and a byte-enable mask. The sequencer drives one address phase and then as many data phases as it needs. It inserts wait states until the target is ready. It closes the transaction at the right moment and hands a completion record back to the agent.

Write data is pulled from the agent by word index. Read data is pushed to the agent with a one-clock valid strobe. The block watches three target responses: device-select, target-ready and stop. From these it decides whether the transaction finished normally, was never claimed, was refused outright, should be retried, or was cut short. Every bus line the block could drive comes with its own output-enable, so the pad ring can build the tristate buffers.

Top module: `pci_init_seq`

## Requirements
- R1: In the address phase the block drives frame low and initiator-ready high, places the latched address on the data bus and the latched command on the command/byte-enable lines, and enables all of them.
- R2: In every data phase the command/byte-enable lines carry the bitwise inverse of the active-high request mask (a set request bit becomes a low, enabled line). In a write, the data bus is driven with `wrData`, which the agent selects by `wordIdx`. In a read, the data bus enable is low.
- R3: A word moves only on a rising edge where initiator-ready, target-ready and device-select are all low; otherwise the phase repeats as a wait state. Each read word appears on `rdData` with `rdValid` high for one clock, one clock after its edge.
- R4: Frame stays low through every data phase except the final one, in which it is high while initiator-ready is still low.
- R5: After the final data phase, the block spends one clock driving both frame and initiator-ready high, then one clock with every enable released, before it can start the next address phase.
- R6: If device-select has not been seen low by the end of the fifth data clock after the address phase, the block ends with master abort and a count of 0. Device-select first seen low in the fifth clock is accepted.
- R7: Stop low, device-select low and target-ready high, with no word moved yet, ends the transaction with retry and a count of 0.
- R8: Stop low with target-ready low moves that word and then ends with disconnect, or with ok if that word was the last one requested. Stop without target-ready after one or more words ends with disconnect.
- R9: Stop low while device-select is high ends the transaction with target abort.
- R10: Each transaction produces exactly one single-clock `donePulse`. It comes with `doneStatus` (0 ok, 1 master abort, 2 target abort, 3 retry, 4 disconnect) and `doneCount`, the number of words moved.
- R11: `reqValid` is accepted only while `busy` is low; it has no effect during a transaction. While idle, all output-enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Start a transaction (taken while idle) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqCmd | input | 4 | Bus command for the address phase |
| reqAddr | input | 32 | Start address |
| reqLen | input | CNT_W | Words to move, 1..MAX_WORDS |
| reqBe | input | 4 | Active-high byte-enable mask for all data phases |
| wrData | input | 32 | Write word selected by wordIdx |
| busy | output | 1 | Transaction in progress |
| wordIdx | output | CNT_W | Index of the next word to move |
| rdValid | output | 1 | Read word available |
| rdData | output | 32 | Read word |
| donePulse | output | 1 | One-clock completion strobe |
| doneStatus | output | 3 | Completion code |
| doneCount | output | CNT_W | Words moved |
| adOut | output | 32 | Address/data bus, outgoing value |
| adIn | input | 32 | Address/data bus, incoming value |
| adOe | output | 1 | Address/data bus enable |
| cbeNOut | output | 4 | Command/byte-enable lines |
| cbeOe | output | 1 | Command/byte-enable enable |
| frameNOut | output | 1 | Frame, active low |
| frameOe | output | 1 | Frame enable |
| irdyNOut | output | 1 | Initiator ready, active low |
| irdyOe | output | 1 | Initiator-ready enable |
| trdyNIn | input | 1 | Target ready, active low |
| devselNIn | input | 1 | Device select, active low |
| stopNIn | input | 1 | Stop, active low |

## Verification
A scripted target answers each data clock with a chosen mix of device-select, target-ready and stop. Burst writes with an immediate claim check the address phase, the write data order and where frame rises. A read with a late claim and scattered wait states checks that only edges with both ready lines low move data. The stop combinations (no data yet, data on the stop edge, stop after data, stop on the last word, stop without a claim) each map to a different completion code. Claims that never come or come on exactly the fifth clock separate master abort from success. A back-to-back run with the request held high measures the turnaround gap and shows that requests are ignored while busy.

// File: rtl/pci_init_pkg.sv
package pci_init_pkg;

  typedef enum logic [2:0] {
    ST_OK     = 3'd0,
    ST_MABORT = 3'd1,
    ST_TABORT = 3'd2,
    ST_RETRY  = 3'd3,
    ST_DISC   = 3'd4
  } xferStatus_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_DATA,
    S_LAST,
    S_TURN
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic        loadReq;
    logic        drvAddr;
    logic        drvData;
    logic        waitTick;
    logic        xfer;
    logic        finish;
    xferStatus_t status;
  } seqStrobe_t;

endpackage

// File: rtl/pci_init_dpath.sv
module pci_init_dpath
  import pci_init_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int BE_W         = 4,
  parameter int CNT_W        = 4,
  parameter int WAIT_W       = 3,
  parameter int DEVSEL_LIMIT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic              reqWrite,
  input  logic [BE_W-1:0]   reqCmd,
  input  logic [DATA_W-1:0] reqAddr,
  input  logic [CNT_W-1:0]  reqLen,
  input  logic [BE_W-1:0]   reqBe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] adIn,
  input  logic              devselNIn,
  output logic              lastWord,
  output logic              noWords,
  output logic              devselOk,
  output logic              waitExpired,
  output logic [CNT_W-1:0]  wordCnt,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [BE_W-1:0]   cbeNOut,
  output logic              cbeOe,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              donePulse,
  output logic [2:0]        doneStatus
);

  logic [DATA_W-1:0] addrQ;
  logic [BE_W-1:0]   cmdQ;
  logic [BE_W-1:0]   beQ;
  logic              writeQ;
  logic [CNT_W-1:0]  lenQ;
  logic [CNT_W-1:0]  cntQ;
  logic [WAIT_W-1:0] waitQ;
  logic              seenQ;
  logic [DATA_W-1:0] rdDataQ;
  logic              rdValidQ;
  logic              doneQ;
  xferStatus_t       statusQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      cmdQ     <= '0;
      beQ      <= '0;
      writeQ   <= 1'b0;
      lenQ     <= '0;
      cntQ     <= '0;
      waitQ    <= '0;
      seenQ    <= 1'b0;
      rdDataQ  <= '0;
      rdValidQ <= 1'b0;
      doneQ    <= 1'b0;
      statusQ  <= ST_OK;
    end else begin
      rdValidQ <= 1'b0;
      doneQ    <= 1'b0;
      if (strb.loadReq) begin
        addrQ  <= reqAddr;
        cmdQ   <= reqCmd;
        beQ    <= reqBe;
        writeQ <= reqWrite;
        lenQ   <= reqLen;
        cntQ   <= '0;
        waitQ  <= '0;
        seenQ  <= 1'b0;
      end
      if (strb.waitTick) begin
        if (!devselNIn) begin
          seenQ <= 1'b1;
        end else if (!seenQ) begin
          waitQ <= waitQ + WAIT_W'(1);
        end
      end
      if (strb.xfer) begin
        cntQ <= cntQ + CNT_W'(1);
        if (!writeQ) begin
          rdDataQ  <= adIn;
          rdValidQ <= 1'b1;
        end
      end
      if (strb.finish) begin
        doneQ   <= 1'b1;
        statusQ <= strb.status;
      end
    end
  end

  assign lastWord    = (cntQ + CNT_W'(1)) == lenQ;
  assign noWords     = (cntQ == '0);
  assign devselOk    = seenQ | ~devselNIn;
  assign waitExpired = (waitQ == WAIT_W'(DEVSEL_LIMIT - 1));
  assign wordCnt     = cntQ;

  assign adOut   = strb.drvAddr ? addrQ : wrData;
  assign adOe    = strb.drvAddr | (strb.drvData & writeQ);
  assign cbeNOut = strb.drvAddr ? cmdQ : ~beQ;
  assign cbeOe   = strb.drvAddr | strb.drvData;

  assign rdValid    = rdValidQ;
  assign rdData     = rdDataQ;
  assign donePulse  = doneQ;
  assign doneStatus = statusQ;

endmodule

// File: rtl/pci_init_ctrl.sv
module pci_init_ctrl
  import pci_init_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       lastWord,
  input  logic       noWords,
  input  logic       devselOk,
  input  logic       waitExpired,
  input  logic       trdyNIn,
  input  logic       devselNIn,
  input  logic       stopNIn,
  output seqStrobe_t strb,
  output logic       busy,
  output logic       frameNOut,
  output logic       frameOe,
  output logic       irdyNOut,
  output logic       irdyOe
);

  seqState_t state;
  seqState_t nextState;
  seqState_t endState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    frameOe   = 1'b0;
    irdyOe    = 1'b0;
    frameNOut = 1'b1;
    irdyNOut  = 1'b1;
    // frame already high in the final phase: skip the extra release clock
    endState  = lastWord ? S_TURN : S_LAST;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          strb.loadReq = 1'b1;
          nextState    = S_ADDR;
        end
      end
      S_ADDR: begin
        frameOe      = 1'b1;
        irdyOe       = 1'b1;
        frameNOut    = 1'b0;
        strb.drvAddr = 1'b1;
        nextState    = S_DATA;
      end
      S_DATA: begin
        frameOe       = 1'b1;
        irdyOe        = 1'b1;
        frameNOut     = lastWord;
        irdyNOut      = 1'b0;
        strb.drvData  = 1'b1;
        strb.waitTick = 1'b1;
        if (!stopNIn) begin
          strb.finish = 1'b1;
          nextState   = endState;
          if (devselNIn) begin
            strb.status = ST_TABORT;
          end else if (!trdyNIn) begin
            strb.xfer   = 1'b1;
            strb.status = lastWord ? ST_OK : ST_DISC;
          end else begin
            strb.status = noWords ? ST_RETRY : ST_DISC;
          end
        end else if (!trdyNIn && !devselNIn) begin
          strb.xfer = 1'b1;
          if (lastWord) begin
            strb.finish = 1'b1;
            strb.status = ST_OK;
            nextState   = S_TURN;
          end
        end else if (!devselOk && waitExpired) begin
          strb.finish = 1'b1;
          strb.status = ST_MABORT;
          nextState   = endState;
        end
      end
      S_LAST: begin
        frameOe      = 1'b1;
        irdyOe       = 1'b1;
        irdyNOut     = 1'b0;
        strb.drvData = 1'b1;
        nextState    = S_TURN;
      end
      S_TURN: begin
        frameOe   = 1'b1;
        irdyOe    = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/pci_init_seq.sv
module pci_init_seq
  import pci_init_pkg::*;
#(
  parameter int  DATA_W       = 32,
  parameter int  BE_W         = 4,
  parameter int  MAX_WORDS    = 8,
  parameter int  DEVSEL_LIMIT = 5,
  localparam int CNT_W        = $clog2(MAX_WORDS + 1),
  localparam int WAIT_W       = $clog2(DEVSEL_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [BE_W-1:0]   reqCmd,
  input  logic [DATA_W-1:0] reqAddr,
  input  logic [CNT_W-1:0]  reqLen,
  input  logic [BE_W-1:0]   reqBe,
  input  logic [DATA_W-1:0] wrData,
  output logic              busy,
  output logic [CNT_W-1:0]  wordIdx,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              donePulse,
  output logic [2:0]        doneStatus,
  output logic [CNT_W-1:0]  doneCount,
  output logic [DATA_W-1:0] adOut,
  input  logic [DATA_W-1:0] adIn,
  output logic              adOe,
  output logic [BE_W-1:0]   cbeNOut,
  output logic              cbeOe,
  output logic              frameNOut,
  output logic              frameOe,
  output logic              irdyNOut,
  output logic              irdyOe,
  input  logic              trdyNIn,
  input  logic              devselNIn,
  input  logic              stopNIn
);

  seqStrobe_t       strb;
  logic             lastWord;
  logic             noWords;
  logic             devselOk;
  logic             waitExpired;
  logic [CNT_W-1:0] wordCnt;

  pci_init_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .lastWord   (lastWord),
    .noWords    (noWords),
    .devselOk   (devselOk),
    .waitExpired(waitExpired),
    .trdyNIn    (trdyNIn),
    .devselNIn  (devselNIn),
    .stopNIn    (stopNIn),
    .strb       (strb),
    .busy       (busy),
    .frameNOut  (frameNOut),
    .frameOe    (frameOe),
    .irdyNOut   (irdyNOut),
    .irdyOe     (irdyOe)
  );

  pci_init_dpath #(
    .DATA_W      (DATA_W),
    .BE_W        (BE_W),
    .CNT_W       (CNT_W),
    .WAIT_W      (WAIT_W),
    .DEVSEL_LIMIT(DEVSEL_LIMIT)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqWrite   (reqWrite),
    .reqCmd     (reqCmd),
    .reqAddr    (reqAddr),
    .reqLen     (reqLen),
    .reqBe      (reqBe),
    .wrData     (wrData),
    .adIn       (adIn),
    .devselNIn  (devselNIn),
    .lastWord   (lastWord),
    .noWords    (noWords),
    .devselOk   (devselOk),
    .waitExpired(waitExpired),
    .wordCnt    (wordCnt),
    .adOut      (adOut),
    .adOe       (adOe),
    .cbeNOut    (cbeNOut),
    .cbeOe      (cbeOe),
    .rdValid    (rdValid),
    .rdData     (rdData),
    .donePulse  (donePulse),
    .doneStatus (doneStatus)
  );

  assign wordIdx   = wordCnt;
  assign doneCount = wordCnt;

endmodule

// File: rtl/pci_init_chk.sv
module pci_init_chk
  import pci_init_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             frameNOut,
  input logic             frameOe,
  input logic             irdyNOut,
  input logic             irdyOe,
  input logic             adOe,
  input logic             cbeOe,
  input logic             donePulse,
  input logic [2:0]       doneStatus,
  input logic [CNT_W-1:0] doneCount
);

  // R4: frame may only be released while the initiator is still ready
  a_r4_frame_rise_irdy_low: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(frameNOut) && frameOe) |-> !irdyNOut);

  // R5: initiator-ready goes high only after frame was already high
  a_r5_irdy_after_frame: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(irdyNOut) && irdyOe) |-> $past(frameNOut));

  // R10: completion strobe lasts one clock
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R6: master abort never reports moved words
  a_r6_mabort_no_words: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse && doneStatus == ST_MABORT) |-> doneCount == '0);

  // R7: retry never reports moved words
  a_r7_retry_no_words: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse && doneStatus == ST_RETRY) |-> doneCount == '0);

  // R11: idle bus has every enable released
  a_r11_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!frameOe && !irdyOe && !adOe && !cbeOe));

endmodule

bind pci_init_seq pci_init_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .frameNOut (frameNOut),
  .frameOe   (frameOe),
  .irdyNOut  (irdyNOut),
  .irdyOe    (irdyOe),
  .adOe      (adOe),
  .cbeOe     (cbeOe),
  .donePulse (donePulse),
  .doneStatus(doneStatus),
  .doneCount (doneCount)
);

// File: tb/pci_init_seq_tb_top.sv
module pci_init_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [3:0]  reqCmd = '0;
  logic [31:0] reqAddr = '0;
  logic [CNT_W-1:0] reqLen = '0;
  logic [3:0]  reqBe = '0;
  logic [31:0] wrData;
  logic        busy;
  logic [CNT_W-1:0] wordIdx;
  logic        rdValid;
  logic [31:0] rdData;
  logic        donePulse;
  logic [2:0]  doneStatus;
  logic [CNT_W-1:0] doneCount;
  logic [31:0] adOut;
  logic [31:0] adIn = '0;
  logic        adOe;
  logic [3:0]  cbeNOut;
  logic        cbeOe;
  logic        frameNOut, frameOe, irdyNOut, irdyOe;
  logic        trdyNIn = 1'b1, devselNIn = 1'b1, stopNIn = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign wrData = 32'hA500_0000 | 32'(wordIdx);

  pci_init_seq dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqCmd(reqCmd), .reqAddr(reqAddr), .reqLen(reqLen), .reqBe(reqBe),
    .wrData(wrData), .busy(busy), .wordIdx(wordIdx), .rdValid(rdValid),
    .rdData(rdData), .donePulse(donePulse), .doneStatus(doneStatus),
    .doneCount(doneCount), .adOut(adOut), .adIn(adIn), .adOe(adOe),
    .cbeNOut(cbeNOut), .cbeOe(cbeOe), .frameNOut(frameNOut), .frameOe(frameOe),
    .irdyNOut(irdyNOut), .irdyOe(irdyOe), .trdyNIn(trdyNIn),
    .devselNIn(devselNIn), .stopNIn(stopNIn)
  );

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  // target script: bit2 devsel, bit1 trdy, bit0 stop (1 = asserted)
  logic [2:0]  scr [0:15];
  int          k = 0;
  logic [31:0] xAd [0:15];
  logic [31:0] xIn [0:15];
  logic [3:0]  xCbe [0:15];
  logic        xFrm [0:15];
  logic        xAdOe [0:15];
  logic [31:0] rdRec [0:15];
  int nx, nr, dataClk, frameLowData, gotDone, addrCnt, gapClk;
  logic [2:0]  gotStatus;
  logic [CNT_W-1:0] gotCount;
  logic [31:0] seenAddr;
  logic [3:0]  seenCmd;
  logic        afterFrame, afterIrdy, prevLastXfer;

  task automatic clearAll();
    for (int i = 0; i < 16; i++) scr[i] = 3'b000;
    nx = 0; nr = 0; dataClk = 0; frameLowData = 0; gotDone = 0;
    addrCnt = 0; gapClk = 0; gotStatus = '0; gotCount = '0;
    afterFrame = 1'b0; afterIrdy = 1'b0;
  endtask

  // responder and monitor
  always @(negedge clk) begin
    logic [2:0] e;
    logic       xf;
    if (frameOe && !frameNOut && irdyNOut) begin
      k = 0;
      {devselNIn, trdyNIn, stopNIn} = 3'b111;
    end else if (irdyOe && !irdyNOut) begin
      e = (k < 16) ? scr[k] : 3'b000;
      {devselNIn, trdyNIn, stopNIn} = ~e;
      adIn = 32'h3C00_0000 | 32'(k);
      k++;
    end else begin
      {devselNIn, trdyNIn, stopNIn} = 3'b111;
    end
    #1;
    xf = 1'b0;
    if (prevLastXfer) begin
      afterFrame = frameNOut;
      afterIrdy  = irdyNOut;
    end
    if (irdyOe && !irdyNOut) begin
      dataClk++;
      if (!frameNOut) frameLowData++;
      if (!trdyNIn && !devselNIn) begin
        xf = 1'b1;
        if (nx < 16) begin
          xAd[nx] = adOut; xIn[nx] = adIn; xCbe[nx] = cbeNOut;
          xFrm[nx] = frameNOut; xAdOe[nx] = adOe;
        end
        nx++;
      end
    end
    prevLastXfer = xf && frameNOut;
    if (frameOe && !frameNOut && irdyNOut) begin
      addrCnt++;
      seenAddr = adOut;
      seenCmd  = cbeNOut;
    end
    if (addrCnt == 1 && !frameOe) gapClk++;
    if (rdValid) begin
      if (nr < 16) rdRec[nr] = rdData;
      nr++;
    end
    if (donePulse) begin
      gotDone++;
      gotStatus = doneStatus;
      gotCount  = doneCount;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitDone(input int want);
    int t = 0;
    while (gotDone < want && t < 300) begin
      @(negedge clk); #2; t++;
    end
    repeat (4) @(negedge clk);
    #2;
  endtask

  task automatic runXfer(input logic wr, input logic [3:0] cmd, input logic [31:0] addr,
                         input int len, input logic [3:0] be);
    reqWrite = wr; reqCmd = cmd; reqAddr = addr; reqLen = CNT_W'(len); reqBe = be;
    reqValid = 1'b1;
    @(negedge clk); #2;
    reqValid = 1'b0;
    waitDone(1);
  endtask

  task automatic prep();
    @(negedge clk); #2;
    clearAll();
  endtask

  task automatic tReset();
    check("R11 idle enables after reset", {26'd0, busy, frameOe, irdyOe, adOe, cbeOe, donePulse}, 32'd0);
  endtask

  task automatic tWriteBurst();
    prep();
    for (int i = 0; i < 4; i++) scr[i] = 3'b110;
    runXfer(1'b1, 4'h7, 32'h1000_0040, 4, 4'b0011);
    check("R1 address value", seenAddr, 32'h1000_0040);
    check("R1 command value", {28'd0, seenCmd}, 32'h7);
    for (int i = 0; i < 4; i++) begin
      check("R2 write data order", xAd[i], 32'hA500_0000 | i);
      check("R2 byte enables inverted", {28'd0, xCbe[i]}, 32'hC);
      check("R4 frame level per phase", {31'd0, xFrm[i]}, (i == 3) ? 32'd1 : 32'd0);
    end
    check("R3 data clocks", dataClk, 4);
    check("R4 data clocks with frame low", frameLowData, 3);
    check("R5 both high after last", {30'd0, afterFrame, afterIrdy}, 32'd3);
    check("R10 status ok", {29'd0, gotStatus}, 0);
    check("R10 word count", {28'd0, gotCount}, 4);
    check("R10 single done", gotDone, 1);
  endtask

  task automatic tReadWaits();
    prep();
    scr[0] = 3'b000; scr[1] = 3'b100; scr[2] = 3'b110;
    scr[3] = 3'b100; scr[4] = 3'b110; scr[5] = 3'b110;
    runXfer(1'b0, 4'h6, 32'h2000_0000, 3, 4'b1111);
    check("R3 transfers", nx, 3);
    check("R3 read strobes", nr, 3);
    check("R3 read word 0", rdRec[0], 32'h3C00_0002);
    check("R3 read word 1", rdRec[1], 32'h3C00_0004);
    check("R3 read word 2", rdRec[2], 32'h3C00_0005);
    check("R2 read bus released", {29'd0, xAdOe[0], xAdOe[1], xAdOe[2]}, 0);
    check("R3 data clocks with waits", dataClk, 6);
    check("R4 frame low until final phase", frameLowData, 5);
    check("R10 read status ok", {29'd0, gotStatus}, 0);
  endtask

  task automatic tMasterAbort();
    prep();
    runXfer(1'b1, 4'h7, 32'h3000_0000, 4, 4'hF);
    check("R6 master abort status", {29'd0, gotStatus}, 1);
    check("R6 master abort count", {28'd0, gotCount}, 0);
    check("R6 wait clocks before abort", frameLowData, 5);
    check("R6 clocks incl release", dataClk, 6);
  endtask

  task automatic tDevselFifth();
    prep();
    scr[4] = 3'b110;
    runXfer(1'b1, 4'h7, 32'h3000_0010, 1, 4'hF);
    check("R6 claim on fifth clock ok", {29'd0, gotStatus}, 0);
    check("R6 claim on fifth clock count", {28'd0, gotCount}, 1);
  endtask

  task automatic tRetry();
    prep();
    scr[0] = 3'b101;
    runXfer(1'b0, 4'h6, 32'h4000_0000, 3, 4'hF);
    check("R7 retry status", {29'd0, gotStatus}, 3);
    check("R7 retry count", {28'd0, gotCount}, 0);
    check("R7 retry clocks", dataClk, 2);
  endtask

  task automatic tDisconnects();
    prep();
    scr[0] = 3'b110; scr[1] = 3'b111;
    runXfer(1'b1, 4'h7, 32'h5000_0000, 4, 4'hF);
    check("R8 stop with data status", {29'd0, gotStatus}, 4);
    check("R8 stop with data count", {28'd0, gotCount}, 2);
    prep();
    scr[0] = 3'b110; scr[1] = 3'b101;
    runXfer(1'b1, 4'h7, 32'h5000_0100, 4, 4'hF);
    check("R8 stop after data status", {29'd0, gotStatus}, 4);
    check("R8 stop after data count", {28'd0, gotCount}, 1);
    prep();
    scr[0] = 3'b110; scr[1] = 3'b111;
    runXfer(1'b1, 4'h7, 32'h5000_0200, 2, 4'hF);
    check("R8 stop on last word status", {29'd0, gotStatus}, 0);
    check("R8 stop on last word count", {28'd0, gotCount}, 2);
  endtask

  task automatic tTargetAbort();
    prep();
    scr[0] = 3'b001;
    runXfer(1'b0, 4'h6, 32'h6000_0000, 3, 4'hF);
    check("R9 target abort status", {29'd0, gotStatus}, 2);
    check("R9 target abort count", {28'd0, gotCount}, 0);
  endtask

  task automatic tBackToBack();
    int t = 0;
    prep();
    scr[0] = 3'b110;
    reqWrite = 1'b1; reqCmd = 4'h7; reqAddr = 32'h7000_0000; reqLen = CNT_W'(1); reqBe = 4'hF;
    reqValid = 1'b1;
    while (addrCnt < 2 && t < 300) begin
      @(negedge clk); #2; t++;
    end
    reqValid = 1'b0;
    check("R11 one done before second start", gotDone, 1);
    check("R5 released clocks between", gapClk, 1);
    waitDone(2);
    check("R11 address phases", addrCnt, 2);
    check("R10 done per transaction", gotDone, 2);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  initial begin
    clearAll();
    prevLastXfer = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #2;
    tReset();
    tWriteBurst();
    tReadWaits();
    tMasterAbort();
    tDevselFifth();
    tRetry();
    tDisconnects();
    tTargetAbort();
    tBackToBack();
    summary();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nChk++;
    nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

endmodule